// File: doc/BRIEF.md
# Sampling-Based Hot Address Tracker

This block sorts logical block addresses into hot and cold for a flash translation layer. Write requests arrive one at a time on a valid/ready interface. Each request carries a 32-bit logical address. One cycle after a request is accepted, the block returns a response. The response says whether the address was already being tracked and whether it now counts as hot.

Tracking state lives in a direct-mapped table of slots. Each slot covers sixteen consecutive addresses. A slot holds a short tag and, for each of its sixteen addresses, a saturating access counter and a recency bit. Sequential traffic therefore shares one slot.

An untracked address is not installed automatically. A free-running pseudo-random sequence is compared with a programmable rate, and only the sampled misses may claim a slot. A sampled miss may still lose to a slot that has been used recently. A periodic decay pulse halves every counter and clears every recency bit, so addresses that go quiet drift back to cold and become replaceable.

Top module: `hot_addr_tracker`

## Requirements
- R1: After a synchronous active-low reset, no slot is valid, `rsp_valid` is low and `req_ready` is high. The first request to any address therefore returns `rsp_hit`=0.
- R2: `req_ready` is low in exactly the cycles in which `decay_tick` is high. A request is taken when `req_valid` and `req_ready` are both high. `rsp_valid` is high in the cycle after each accepted request and low otherwise.
- R3: Address bits [3:0] select the sub-entry, bits [11:4] select the slot and bits [15:12] form the stored tag. Bits [31:16] have no effect. Addresses that agree in bits [15:4] share one slot and keep separate counters.
- R4: The sampler is a 16-bit shift register seeded with 16'hACE1. Each step shifts left and inserts bit15^bit13^bit12^bit10 at bit 0, and it steps once after every accepted request. A miss is sampled when the current value is below `sample_rate`. An unsampled miss changes no tracking state.
- R5: A sampled miss whose slot is empty, or whose slot has all sixteen recency bits clear, installs the new tag. All sixteen counters and recency bits of that slot are cleared, and then the requested sub-entry is set to count 1 with its recency bit set.
- R6: A sampled miss whose slot holds a different tag with any recency bit set is dropped. The slot keeps its tag, counters and recency bits.
- R7: A hit, meaning the slot is valid and the tag matches, increments the sub-entry counter, saturating at 15, and sets its recency bit.
- R8: `rsp_hot` is 1 only for a hit whose counter after the increment is at least HOT_THR (default 4). A miss always reports `rsp_hot`=0.
- R9: In a cycle with `decay_tick` high, every counter is shifted right by one and every recency bit is cleared. Tags and slot validity are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A request can be taken this cycle |
| req_lba | input | 32 | Logical address of the request |
| sample_rate | input | 16 | Admission threshold for missed addresses |
| decay_tick | input | 1 | Aging pulse: halve counters, clear recency |
| rsp_valid | output | 1 | Response for the request accepted in the previous cycle |
| rsp_hit | output | 1 | The address was tracked before this request |
| rsp_hot | output | 1 | The address is classified hot |

## Verification
The bench targets several corner cases, each of which a specific design fault would expose:
- **Saturation.** The bench drives one address well past 15 hits. A counter that wraps would drop the address from hot back to cold.
- **Slot contention.** A missed address contends for a slot that holds recent traffic. A design that ignores the recency guard would evict the working entry and make later hits miss.
- **Aging.** A decay pulse arrives with a request held on the input. A design that accepts that request, or that keeps the recency bits through the pulse, would produce an extra response or refuse the replacement that should follow.
- **Sampling.** A behavioural model of the sampler runs alongside the design at zero, full and middle rates. Any off-by-one in the comparison or in the stepping order shows up as a wrongly admitted or wrongly dropped address.

// File: rtl/hat_pkg.sv
// Shared constants and types for the hot address tracker.
// Assumes a fixed address split: 4 sub bits, 12 primary bits, 32-bit address.
package hat_pkg;
    localparam int LBA_W  = 32;
    localparam int SUB_W  = 4;
    localparam int PRI_W  = 12;
    localparam int CNT_W  = 4;
    localparam int RATE_W = 16;
    localparam int NSUB   = 1 << SUB_W;

    // One tracked address inside a slot: access count and recency flag.
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rec;
    } sub_ent_t;

    // All sub-entries of one slot.
    typedef sub_ent_t [NSUB-1:0] sub_vec_t;
endpackage

// File: rtl/hat_sampler.sv
// Admission sampler: a 16-bit Fibonacci shift register compared with a rate.
// Assumes the caller pulses step once per accepted request; admit is
// combinational from the current register value.
module hat_sampler
    import hat_pkg::*;
#(
    parameter logic [RATE_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [RATE_W-1:0] rate,
    output logic              admit
);
    logic [RATE_W-1:0] lfsr_q;
    logic              fb;

    // Feedback taps for a maximal-length 16-bit sequence.
    always_comb fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    // Advance the sequence after each use.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lfsr_q <= SEED;
        else if (step)
            lfsr_q <= {lfsr_q[RATE_W-2:0], fb};
    end

    // Sample when the pseudo-random value is below the programmed rate.
    always_comb admit = (lfsr_q < rate);

    AST_LFSR_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);                                                   // R4
    AST_LFSR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(lfsr_q));                                      // R4
endmodule

// File: rtl/hat_table.sv
// Direct-mapped slot storage: per slot a valid bit, a tag and sixteen
// sub-entries. It has one combinational read port, and one write port at
// the same index. The decay pulse ages every slot in parallel.
// Assumes write and decay are never requested in the same cycle.
module hat_table
    import hat_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int TAG_W = PRI_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output sub_vec_t         rd_subs,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  sub_vec_t         wr_subs,
    input  logic             decay
);
    localparam int NSLOT = 1 << IDX_W;

    logic             vld_q  [NSLOT];
    logic [TAG_W-1:0] tag_q  [NSLOT];
    sub_vec_t         subs_q [NSLOT];

    // Read port: present the addressed slot.
    always_comb begin
        rd_valid = vld_q[idx];
        rd_tag   = tag_q[idx];
        rd_subs  = subs_q[idx];
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic any_rec;

        // Recency summary of this slot, used by the aging check below.
        always_comb begin
            any_rec = 1'b0;
            for (int k = 0; k < NSUB; k++) any_rec = any_rec | subs_q[s][k].rec;
        end

        // Slot state: reset, age on decay, or take a write at its index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s]  <= 1'b0;
                tag_q[s]  <= '0;
                subs_q[s] <= '0;
            end else if (decay) begin
                for (int k = 0; k < NSUB; k++) begin
                    subs_q[s][k].cnt <= subs_q[s][k].cnt >> 1;
                    subs_q[s][k].rec <= 1'b0;
                end
            end else if (wr_en && (idx == IDX_W'(s))) begin
                vld_q[s]  <= 1'b1;
                tag_q[s]  <= wr_tag;
                subs_q[s] <= wr_subs;
            end
        end

        AST_DECAY_CLEARS_REC: assert property (@(posedge clk) disable iff (!rst_n)
            decay |=> !any_rec);                                          // R9
        AST_DECAY_KEEPS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
            decay |=> $stable(tag_q[s]) && $stable(vld_q[s]));           // R9
    end

    AST_NO_WRITE_ON_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
        decay |-> !wr_en);                                                // R9
endmodule

// File: rtl/hat_update.sv
// Lookup and update decision for one request, purely combinational.
// It decides hit or miss, the new sub-entry contents, whether the slot is
// written, and the hot flag. Assumes HOT_THR >= 2, so a new install is
// never hot.
module hat_update
    import hat_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int HOT_THR = 4
) (
    input  logic             go,
    input  logic             slot_valid,
    input  logic [TAG_W-1:0] slot_tag,
    input  sub_vec_t         slot_subs,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [SUB_W-1:0] req_sub,
    input  logic             admit,
    output logic             hit,
    output logic             hot,
    output logic             busy_slot,
    output logic             wr_en,
    output sub_vec_t         wr_subs,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [CNT_W-1:0] new_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Tag compare and recency summary of the addressed slot.
    always_comb begin
        hit       = slot_valid && (slot_tag == req_tag);
        busy_slot = 1'b0;
        for (int k = 0; k < NSUB; k++) busy_slot = busy_slot | slot_subs[k].rec;
        busy_slot = slot_valid && busy_slot;
    end

    // Saturating increment of the addressed counter.
    always_comb begin
        cur_cnt = slot_subs[req_sub].cnt;
        new_cnt = (cur_cnt == CNT_MAX) ? CNT_MAX : cur_cnt + CNT_W'(1);
    end

    // Build the new slot image: bump on hit, fresh install on admitted miss.
    always_comb begin
        wr_en   = 1'b0;
        wr_subs = slot_subs;
        if (go && hit) begin
            wr_en                = 1'b1;
            wr_subs[req_sub].cnt = new_cnt;
            wr_subs[req_sub].rec = 1'b1;
        end else if (go && admit && !busy_slot) begin
            wr_en                = 1'b1;
            wr_subs              = '0;
            wr_subs[req_sub].cnt = CNT_W'(1);
            wr_subs[req_sub].rec = 1'b1;
        end
    end

    // Hot only when a hit pushes the count to the threshold or beyond.
    always_comb hot = hit && (int'(new_cnt) >= HOT_THR);
endmodule

// File: rtl/hot_addr_tracker.sv
// Top of the hot address tracker. It accepts one request per cycle unless
// a decay pulse is present, looks up and updates the slot table in the
// same cycle, and registers the response for the next cycle.
// Assumes the address split of hat_pkg and HOT_THR >= 2.
module hot_addr_tracker
    import hat_pkg::*;
#(
    parameter int                IDX_W   = 8,
    parameter int                HOT_THR = 4,
    parameter logic [RATE_W-1:0] SEED    = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LBA_W-1:0]  req_lba,
    input  logic [RATE_W-1:0] sample_rate,
    input  logic              decay_tick,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_hot
);
    localparam int TAG_W = PRI_W - IDX_W;
    localparam int IDX_LO = SUB_W;
    localparam int TAG_LO = SUB_W + IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             accept;
    logic [SUB_W-1:0] req_sub;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             admit;
    logic             slot_valid;
    logic [TAG_W-1:0] slot_tag;
    sub_vec_t         slot_subs;
    logic             hit, hot, busy_slot, wr_en;
    sub_vec_t         wr_subs;
    logic [CNT_W-1:0] cur_cnt, new_cnt;

    // Handshake: aging takes the cycle, so no request is taken during it.
    always_comb begin
        req_ready = !decay_tick;
        accept    = req_valid && req_ready;
    end

    // Split the address into sub-entry, slot index and stored tag.
    always_comb begin
        req_sub = req_lba[SUB_W-1:0];
        req_idx = req_lba[IDX_LO +: IDX_W];
        req_tag = req_lba[TAG_LO +: TAG_W];
    end

    hat_sampler #(.SEED(SEED)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .rate  (sample_rate),
        .admit (admit)
    );

    hat_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx      (req_idx),
        .rd_valid (slot_valid),
        .rd_tag   (slot_tag),
        .rd_subs  (slot_subs),
        .wr_en    (wr_en),
        .wr_tag   (req_tag),
        .wr_subs  (wr_subs),
        .decay    (decay_tick)
    );

    hat_update #(.TAG_W(TAG_W), .HOT_THR(HOT_THR)) u_update (
        .go         (accept),
        .slot_valid (slot_valid),
        .slot_tag   (slot_tag),
        .slot_subs  (slot_subs),
        .req_tag    (req_tag),
        .req_sub    (req_sub),
        .admit      (admit),
        .hit        (hit),
        .hot        (hot),
        .busy_slot  (busy_slot),
        .wr_en      (wr_en),
        .wr_subs    (wr_subs),
        .cur_cnt    (cur_cnt),
        .new_cnt    (new_cnt)
    );

    // Response register: one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_hot   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && hit;
            rsp_hot   <= accept && hot;
        end
    end

    AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid);                                            // R2
    AST_NO_RSP_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !rsp_valid);                                          // R2
    AST_MISS_IS_COLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> !rsp_hot);                            // R8
    AST_UNSAMPLED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit && !admit) |-> !wr_en);                           // R4
    AST_BUSY_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !hit && busy_slot) |-> !wr_en);                        // R6
    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit && cur_cnt == CNT_MAX) |-> new_cnt == CNT_MAX);    // R7
    AST_HIT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |-> (wr_en && wr_subs[req_sub].rec));             // R7
endmodule

// File: tb/tb_hot_addr_tracker.sv
// Bench: behavioural reference model compared with the design every clock.
module tb_hot_addr_tracker;
    localparam int HOT = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_lba;
    logic [15:0] sample_rate;
    logic        decay_tick;
    logic        rsp_valid, rsp_hit, rsp_hot;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string phase = "R1";

    // Reference state: plain arrays keyed by slot and sub-entry.
    bit          m_vld [256];
    int          m_tag [256];
    int          m_cnt [256][16];
    bit          m_rec [256][16];
    logic [15:0] m_lfsr;
    bit          e_valid, e_hit, e_hot;

    hot_addr_tracker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_lba(req_lba), .sample_rate(sample_rate), .decay_tick(decay_tick),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hot(rsp_hot)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_vld[s]) begin
                m_vld[s] = 0;
                m_tag[s] = 0;
                for (int k = 0; k < 16; k++) begin
                    m_cnt[s][k] = 0;
                    m_rec[s][k] = 0;
                end
            end
            m_lfsr  = 16'hACE1;
            e_valid = 0; e_hit = 0; e_hot = 0;
        end else begin
            check("R2", "req_ready", int'(req_ready), int'(!decay_tick));
            e_valid = 0; e_hit = 0; e_hot = 0;
            if (decay_tick) begin
                foreach (m_vld[s])
                    for (int k = 0; k < 16; k++) begin
                        m_cnt[s][k] = m_cnt[s][k] / 2;
                        m_rec[s][k] = 0;
                    end
            end else if (req_valid) begin
                int  sl, tg, sb;
                bit  busy;
                sb = int'(req_lba[3:0]);
                sl = int'(req_lba[11:4]);
                tg = int'(req_lba[15:12]);
                e_valid = 1;
                if (m_vld[sl] && m_tag[sl] == tg) begin
                    e_hit = 1;
                    if (m_cnt[sl][sb] < 15) m_cnt[sl][sb]++;
                    m_rec[sl][sb] = 1;
                    e_hot = (m_cnt[sl][sb] >= HOT);
                end else if (m_lfsr < sample_rate) begin
                    busy = 0;
                    for (int k = 0; k < 16; k++) busy |= m_rec[sl][k];
                    if (!m_vld[sl] || !busy) begin
                        m_vld[sl] = 1;
                        m_tag[sl] = tg;
                        for (int k = 0; k < 16; k++) begin
                            m_cnt[sl][k] = 0;
                            m_rec[sl][k] = 0;
                        end
                        m_cnt[sl][sb] = 1;
                        m_rec[sl][sb] = 1;
                    end
                end
                m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            end
        end
    end

    // Compare registered outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            check(phase, "rsp_valid", int'(rsp_valid), int'(e_valid));
            if (e_valid) begin
                check(phase, "rsp_hit", int'(rsp_hit), int'(e_hit));
                check(phase, "rsp_hot", int'(rsp_hot), int'(e_hot));
            end
        end
    end

    // Drive one cycle of stimulus, changing inputs just after the falling edge.
    task automatic cyc(bit v, logic [31:0] a, bit d);
        @(negedge clk);
        #1;
        req_valid  = v;
        req_lba    = a;
        decay_tick = d;
    endtask

    task automatic send(logic [31:0] a);
        cyc(1, a, 0);
    endtask

    // Send one address and check the response it produces in the next cycle.
    task automatic send_expect(string req, logic [31:0] a, bit hit, bit hot);
        send(a);
        @(posedge clk);
        @(negedge clk);
        #2;
        check(req, "directed rsp_hit", int'(rsp_hit), int'(hit));
        check(req, "directed rsp_hot", int'(rsp_hot), int'(hot));
        req_valid = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        rst_n = 0; req_valid = 0; req_lba = '0; decay_tick = 0; sample_rate = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        check("R1", "req_ready after reset", int'(req_ready), 1);
        rst_n = 1;
        phase = "R1";
        send_expect("R1", 32'h0000_1230, 0, 0);

        // Zero rate: misses are never admitted.
        phase = "R4";
        sample_rate = 16'h0000;
        send_expect("R4", 32'h0000_5670, 0, 0);
        send_expect("R4", 32'h0000_5670, 0, 0);

        // Full rate: admit, then count up to hot.
        sample_rate = 16'hFFFF;
        phase = "R5";
        send(32'h0000_1230);
        phase = "R7";
        send(32'h0000_1230);
        send(32'h0000_1230);
        phase = "R8";
        send(32'h0000_1230);
        cyc(0, '0, 0);
        cyc(0, '0, 0);

        // Same slot from a neighbour and from different upper bits.
        phase = "R3";
        send(32'h0000_1231);
        send(32'hABCD_1230);
        cyc(0, '0, 0);
        cyc(0, '0, 0);

        // Saturation past 15.
        phase = "R7";
        for (int i = 0; i < 20; i++) send(32'h0000_1230);
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        send_expect("R7", 32'h0000_1230, 1, 1);

        // Busy slot keeps its occupant.
        phase = "R6";
        send(32'h0000_2230);
        send(32'h0000_2230);
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        send_expect("R6", 32'h0000_1230, 1, 1);

        // Decay with a request held: not taken, then aging applied.
        phase = "R2";
        cyc(1, 32'h0000_2230, 1);
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        phase = "R9";
        send(32'h0000_1231);
        cyc(0, '0, 1);
        cyc(0, '0, 0);

        // After aging, a sampled miss replaces the idle slot.
        phase = "R5";
        send(32'h0000_2230);
        send(32'h0000_1230);
        send(32'h0000_2230);
        cyc(0, '0, 0);
        cyc(0, '0, 0);

        // Mixed traffic with several rates and periodic decay.
        phase = "R4";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            if (i % 500 == 0)
                sample_rate = (i % 1500 == 0) ? 16'h8000 :
                              (i % 1000 == 0) ? 16'h3000 : 16'hE000;
            a = {$urandom_range(0, 65535) & 32'hFFFF, 4'($urandom_range(0, 3)),
                 8'($urandom_range(0, 3)), 4'($urandom_range(0, 15))};
            if ($urandom_range(0, 40) == 0)
                cyc($urandom_range(0, 1) == 1, a, 1);
            else if ($urandom_range(0, 5) == 0)
                cyc(0, a, 0);
            else
                cyc(1, a, 0);
        end
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        finish_run();
    end
endmodule